// File: doc/BRIEF.md
# PWM Interrupt Status Controller

This block gathers single-cycle event pulses from a multi-channel PWM engine into two status registers and raises one interrupt line. The first status register holds per-channel end-of-period and per-channel fault flags. The second holds the transfer events (write-ready, end-of-transfer, buffer-empty, underrun) and the per-comparator match and update flags. Each register has its own mask, which is changed through a set-only enable register and a clear-only disable register. The interrupt is the OR of every flag ANDed with its mask bit.

The block also holds, for each comparator, a double-buffered comparison value and configuration. Software writes the update copies. A per-comparator state machine records which copies are pending: `SH_IDLE` (nothing pending), `SH_VAL` (value pending), `SH_CFG` (configuration pending) and `SH_BOTH`. A write of the value moves `SH_IDLE` to `SH_VAL` and `SH_CFG` to `SH_BOTH`. A write of the configuration moves `SH_IDLE` to `SH_CFG` and `SH_VAL` to `SH_BOTH`. At a load boundary every pending copy is transferred and the machine returns to `SH_IDLE`, unless a write lands in the same cycle. In that case the machine goes to the state of the freshly written copy. A load boundary is an end-of-period pulse of channel 0 that closes the comparator's update period. The update period is a programmable count of 1 to 16 channel-0 periods.

The bus is a simple register port. Read data is combinational from the address. A read strobe on a status address clears that register at the clock edge. Word addresses: 0 first status, 1 first enable, 2 first disable, 3 first mask; 4 second status, 5 second enable, 6 second disable, 7 second mask; 8+2k comparator k value, 9+2k comparator k configuration. A write to 8+2k or 9+2k loads the update copy. A read of those addresses returns the active copy.

Top module: `pwm_irq_ctrl`

## Requirements
- R1: An end-of-period pulse on channel i sets bit i of the first status register, and a fault pulse on channel i sets bit 16+i.
- R2: In the second status register, a write-ready pulse sets bit 0, an underrun pulse sets bit 3, a match on comparator k sets bit 8+k and an update on comparator k sets bit 16+k. Bit 1 (end-of-transfer) and bit 2 (buffer-empty) follow their input levels one cycle later.
- R3: A read strobe at address 0 returns the current first status value and clears every bit of it.
- R4: A read strobe at address 4 returns the current second status value and clears bits 0, 3, 8+k and 16+k; bits 1 and 2 are not cleared.
- R5: An event pulse in the same cycle as the clearing read leaves its flag set afterwards.
- R6: Writing 1s to an enable register (1 or 5) sets those mask bits, and writing 1s to a disable register (2 or 6) clears them. Writing 0s changes nothing. The masks read back at 3 and 7.
- R7: The irq output is 1 exactly when some status flag and its mask bit are both 1.
- R8: A value written at 8+2k becomes the active comparison value (read at 8+2k) only at comparator k's load boundary; before that the old active value remains.
- R9: Configuration fields are bit 0 comparison enable and bits 7:4 update period minus one. A written configuration becomes active at the load boundary, and a boundary with no configuration written since the last load leaves the active configuration unchanged.
- R10: A load boundary is the (P)th channel-0 end-of-period pulse counted from the previous boundary, where P is the active update period. The update flag is raised only at a boundary where a copy is pending.
- R11: cmp_match[k] is a single-cycle pulse when the channel-0 count first equals the active value of an enabled comparator k; it stays 0 while the comparator is disabled.
- R12: After reset both status registers, both masks, the active values and configurations read 0, and irq is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears a status register) |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| ch_eop | input | N_CH | Per-channel end-of-period pulses |
| ch_fault | input | N_CH | Per-channel fault pulses |
| xfer_wrdy | input | 1 | Write-ready pulse |
| xfer_endtx | input | 1 | End-of-transfer level |
| xfer_bufe | input | 1 | Buffer-empty level |
| xfer_unre | input | 1 | Underrun pulse |
| ch0_cnt | input | CNT_W | Channel-0 counter value |
| cmp_match | output | N_CMP | Per-comparator match pulses |
| irq | output | 1 | Interrupt request |

## Verification
The in-line assertions watch these rules on every cycle: a pulsed flag is set after its event, even when a read clears the register in the same cycle; a flag holds while no read strobe arrives; a clearing read with no new event leaves the clearable bits empty; an enable write sets and a disable write clears exactly the written mask bits; the active value and configuration change only at a load boundary, and a configuration that was not written never loads; a match pulse never lasts two cycles. The bench scenarios show what no single-cycle property covers. These are the read value returned before a clear, the interrupt following the AND of flags and masks, the counting of channel-0 periods up to a programmed update period, and the match pulse seen at the port when the counter reaches a freshly loaded value.

// File: rtl/pwm_irq_pkg.sv
package pwm_irq_pkg;

    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_VAL  = 2'd1,
        SH_CFG  = 2'd2,
        SH_BOTH = 2'd3
    } sh_state_t;

    localparam int REG_W       = 32;
    localparam int ADDR_W      = 4;
    localparam int ADR_SR1     = 0;
    localparam int ADR_IER1    = 1;
    localparam int ADR_IDR1    = 2;
    localparam int ADR_IMR1    = 3;
    localparam int ADR_SR2     = 4;
    localparam int ADR_IER2    = 5;
    localparam int ADR_IDR2    = 6;
    localparam int ADR_IMR2    = 7;
    localparam int ADR_CMP     = 8;

    localparam int FAULT_LSB   = 16;
    localparam int WRDY_BIT    = 0;
    localparam int ENDTX_BIT   = 1;
    localparam int BUFE_BIT    = 2;
    localparam int UNRE_BIT    = 3;
    localparam int MATCH_LSB   = 8;
    localparam int UPD_LSB     = 16;

    localparam int CFG_W       = 8;
    localparam int CFG_EN_BIT  = 0;
    localparam int CFG_UPR_LSB = 4;
    localparam int UPR_W       = 4;

endpackage

// File: rtl/pwm_irq_mask.sv
module pwm_irq_mask #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask
);

    logic [W-1:0] set_bits;
    logic [W-1:0] clr_bits;

    always_comb begin
        set_bits = set_we ? wdata : '0;
        clr_bits = clr_we ? wdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '0;
        end else begin
            mask <= (mask | set_bits) & ~clr_bits;
        end
    end

    // R6
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && !clr_we) |=> ((mask & $past(wdata)) == $past(wdata)));

    // R6
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((mask & $past(wdata)) == '0));

    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> (mask == $past(mask)));

endmodule

// File: rtl/pwm_irq_status.sv
module pwm_irq_status #(
    parameter int           W        = 32,
    parameter logic [W-1:0] LVL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] lvl,
    input  logic         rd_clr,
    output logic [W-1:0] flags
);

    logic [W-1:0] pulse_evt;
    logic [W-1:0] kept;
    logic [W-1:0] flags_d;

    always_comb begin
        pulse_evt = evt & ~LVL_MASK;
        kept      = rd_clr ? '0 : flags;
        flags_d   = ((kept | pulse_evt) & ~LVL_MASK) | (lvl & LVL_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= flags_d;
        end
    end

    // R5
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulse_evt) |=> ((flags & $past(pulse_evt)) == $past(pulse_evt)));

    // R3
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && pulse_evt == '0) |=> ((flags & ~LVL_MASK) == '0));

    // R1
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr) |=> ((flags & $past(flags) & ~LVL_MASK) == ($past(flags) & ~LVL_MASK)));

endmodule

// File: rtl/pwm_cmp_shadow.sv
module pwm_cmp_shadow
    import pwm_irq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch0_eop,
    input  logic [CNT_W-1:0] ch0_cnt,
    input  logic             val_we,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] wdata,
    output logic [CNT_W-1:0] act_val,
    output logic [CFG_W-1:0] act_cfg,
    output logic             match,
    output logic             upd
);

    sh_state_t        state_q;
    sh_state_t        state_d;
    logic [CNT_W-1:0] shd_val;
    logic [CFG_W-1:0] shd_cfg;
    logic [UPR_W-1:0] upd_cnt;
    logic [UPR_W-1:0] upr;
    logic             boundary;
    logic             val_pend;
    logic             cfg_pend;
    logic             load_val;
    logic             load_cfg;
    logic             eq;
    logic             eq_q;

    always_comb begin
        upr      = act_cfg[CFG_UPR_LSB +: UPR_W];
        boundary = ch0_eop && (upd_cnt == upr);
        eq       = act_cfg[CFG_EN_BIT] && (ch0_cnt == act_val);
        match    = eq && !eq_q;
    end

    // next-state process
    always_comb begin
        val_pend = 1'b0;
        cfg_pend = 1'b0;
        unique case (state_q)
            SH_IDLE: begin val_pend = 1'b0; cfg_pend = 1'b0; end
            SH_VAL:  begin val_pend = 1'b1; cfg_pend = 1'b0; end
            SH_CFG:  begin val_pend = 1'b0; cfg_pend = 1'b1; end
            SH_BOTH: begin val_pend = 1'b1; cfg_pend = 1'b1; end
        endcase
        load_val = boundary && val_pend;
        load_cfg = boundary && cfg_pend;
        upd      = boundary && (val_pend || cfg_pend);
        state_d  = state_q;
        unique case ({(val_pend && !boundary) || val_we,
                      (cfg_pend && !boundary) || cfg_we})
            2'b00: state_d = SH_IDLE;
            2'b10: state_d = SH_VAL;
            2'b01: state_d = SH_CFG;
            2'b11: state_d = SH_BOTH;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output/datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_val <= '0;
            shd_cfg <= '0;
            act_val <= '0;
            act_cfg <= '0;
            upd_cnt <= '0;
            eq_q    <= 1'b0;
        end else begin
            eq_q <= eq;
            if (val_we) shd_val <= wdata[CNT_W-1:0];
            if (cfg_we) shd_cfg <= wdata[CFG_W-1:0];
            if (load_val) act_val <= shd_val;
            if (load_cfg) act_cfg <= shd_cfg;
            if (ch0_eop) upd_cnt <= boundary ? '0 : upd_cnt + 1'b1;
        end
    end

    // R11
    match_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> !match);

    // R8
    val_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && (state_q == SH_VAL || state_q == SH_BOTH)) |=> (act_val == $past(shd_val)));

    // R10
    no_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!boundary) |=> (act_val == $past(act_val) && act_cfg == $past(act_cfg)));

    // R9
    cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_IDLE || state_q == SH_VAL) |=> (act_cfg == $past(act_cfg)));

endmodule

// File: rtl/pwm_irq_ctrl.sv
module pwm_irq_ctrl
    import pwm_irq_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int N_CMP = 2,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [N_CH-1:0]   ch_eop,
    input  logic [N_CH-1:0]   ch_fault,
    input  logic              xfer_wrdy,
    input  logic              xfer_endtx,
    input  logic              xfer_bufe,
    input  logic              xfer_unre,
    input  logic [CNT_W-1:0]  ch0_cnt,
    output logic [N_CMP-1:0]  cmp_match,
    output logic              irq
);

    localparam logic [REG_W-1:0] SR2_LVL = (REG_W'(1) << ENDTX_BIT) | (REG_W'(1) << BUFE_BIT);

    logic [REG_W-1:0] sr1_evt, sr2_evt, sr2_lvl;
    logic [REG_W-1:0] sr1, sr2, imr1, imr2;
    logic [N_CMP-1:0] cmp_upd;
    logic [N_CMP-1:0] val_we, cfg_we;
    logic [CNT_W-1:0] act_val [N_CMP];
    logic [CFG_W-1:0] act_cfg [N_CMP];
    logic             rd_sr1, rd_sr2;

    always_comb begin
        sr1_evt = '0;
        sr1_evt[N_CH-1:0]         = ch_eop;
        sr1_evt[FAULT_LSB +: N_CH] = ch_fault;
        sr2_evt = '0;
        sr2_evt[WRDY_BIT]          = xfer_wrdy;
        sr2_evt[UNRE_BIT]          = xfer_unre;
        sr2_evt[MATCH_LSB +: N_CMP] = cmp_match;
        sr2_evt[UPD_LSB +: N_CMP]   = cmp_upd;
        sr2_lvl = '0;
        sr2_lvl[ENDTX_BIT]         = xfer_endtx;
        sr2_lvl[BUFE_BIT]          = xfer_bufe;
        rd_sr1 = reg_rd && (reg_addr == ADDR_W'(ADR_SR1));
        rd_sr2 = reg_rd && (reg_addr == ADDR_W'(ADR_SR2));
    end

    pwm_irq_status #(.W(REG_W), .LVL_MASK('0)) u_sr1 (
        .clk(clk), .rst_n(rst_n), .evt(sr1_evt), .lvl('0),
        .rd_clr(rd_sr1), .flags(sr1)
    );

    pwm_irq_status #(.W(REG_W), .LVL_MASK(SR2_LVL)) u_sr2 (
        .clk(clk), .rst_n(rst_n), .evt(sr2_evt), .lvl(sr2_lvl),
        .rd_clr(rd_sr2), .flags(sr2)
    );

    pwm_irq_mask #(.W(REG_W)) u_imr1 (
        .clk(clk), .rst_n(rst_n),
        .set_we(reg_wr && reg_addr == ADDR_W'(ADR_IER1)),
        .clr_we(reg_wr && reg_addr == ADDR_W'(ADR_IDR1)),
        .wdata(reg_wdata), .mask(imr1)
    );

    pwm_irq_mask #(.W(REG_W)) u_imr2 (
        .clk(clk), .rst_n(rst_n),
        .set_we(reg_wr && reg_addr == ADDR_W'(ADR_IER2)),
        .clr_we(reg_wr && reg_addr == ADDR_W'(ADR_IDR2)),
        .wdata(reg_wdata), .mask(imr2)
    );

    for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
        assign val_we[k] = reg_wr && (reg_addr == ADDR_W'(ADR_CMP + 2 * k));
        assign cfg_we[k] = reg_wr && (reg_addr == ADDR_W'(ADR_CMP + 2 * k + 1));

        pwm_cmp_shadow #(.CNT_W(CNT_W)) u_shadow (
            .clk(clk), .rst_n(rst_n),
            .ch0_eop(ch_eop[0]), .ch0_cnt(ch0_cnt),
            .val_we(val_we[k]), .cfg_we(cfg_we[k]), .wdata(reg_wdata),
            .act_val(act_val[k]), .act_cfg(act_cfg[k]),
            .match(cmp_match[k]), .upd(cmp_upd[k])
        );
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(ADR_SR1):  reg_rdata = sr1;
            ADDR_W'(ADR_IMR1): reg_rdata = imr1;
            ADDR_W'(ADR_SR2):  reg_rdata = sr2;
            ADDR_W'(ADR_IMR2): reg_rdata = imr2;
            default: begin
                for (int k = 0; k < N_CMP; k++) begin
                    if (reg_addr == ADDR_W'(ADR_CMP + 2 * k))
                        reg_rdata = REG_W'(act_val[k]);
                    if (reg_addr == ADDR_W'(ADR_CMP + 2 * k + 1))
                        reg_rdata = REG_W'(act_cfg[k]);
                end
            end
        endcase
    end

    assign irq = (|(sr1 & imr1)) || (|(sr2 & imr2));

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imr1 == '0 && imr2 == '0) |-> !irq);

endmodule

// File: tb/pwm_irq_ctrl_tb_top.sv
module pwm_irq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_CH  = 4;
    localparam int N_CMP = 2;
    localparam int CNT_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [3:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [N_CH-1:0]   ch_eop = '0;
    logic [N_CH-1:0]   ch_fault = '0;
    logic              xfer_wrdy = 1'b0;
    logic              xfer_endtx = 1'b0;
    logic              xfer_bufe = 1'b0;
    logic              xfer_unre = 1'b0;
    logic [CNT_W-1:0]  ch0_cnt = '0;
    logic [N_CMP-1:0]  cmp_match;
    logic              irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwm_irq_ctrl #(.N_CH(N_CH), .N_CMP(N_CMP), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ch_eop(ch_eop), .ch_fault(ch_fault), .xfer_wrdy(xfer_wrdy),
        .xfer_endtx(xfer_endtx), .xfer_bufe(xfer_bufe), .xfer_unre(xfer_unre),
        .ch0_cnt(ch0_cnt), .cmp_match(cmp_match), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic do_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ch0_periods(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ch_eop[0] = 1'b1;
            @(negedge clk); ch_eop[0] = 1'b0;
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 12; a++) begin
            peek(4'(a), v);
            chk("R12 reset readback", v, 32'h0);
        end
        chk("R12 reset irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_sr1;
        logic [31:0] v;
        @(negedge clk); ch_eop[2] = 1'b1; ch_fault[1] = 1'b1;
        @(negedge clk); ch_eop[2] = 1'b0; ch_fault[1] = 1'b0;
        peek(4'd0, v);
        chk("R1 eop2 and fault1 flags", v, 32'h0002_0004);
        chk("R7 no irq with masks clear", {31'h0, irq}, 32'h0);
        do_rd(4'd0, v);
        chk("R3 read returns flags", v, 32'h0002_0004);
        peek(4'd0, v);
        chk("R3 flags cleared after read", v, 32'h0);
    endtask

    task automatic t_sr2;
        logic [31:0] v;
        @(negedge clk); xfer_wrdy = 1'b1; xfer_unre = 1'b1; xfer_endtx = 1'b1;
        @(negedge clk); xfer_wrdy = 1'b0; xfer_unre = 1'b0;
        peek(4'd4, v);
        chk("R2 wrdy unre endtx flags", v, 32'h0000_000B);
        do_rd(4'd4, v);
        chk("R4 read returns flags", v, 32'h0000_000B);
        peek(4'd4, v);
        chk("R4 endtx kept after read", v, 32'h0000_0002);
        @(negedge clk); xfer_endtx = 1'b0; xfer_bufe = 1'b1;
        @(negedge clk);
        peek(4'd4, v);
        chk("R2 bufe follows level", v, 32'h0000_0004);
        xfer_bufe = 1'b0;
        @(negedge clk);
        peek(4'd4, v);
        chk("R2 level flags drop", v, 32'h0);
    endtask

    task automatic t_collision;
        logic [31:0] v;
        @(negedge clk); ch_fault[0] = 1'b1;
        @(negedge clk); ch_fault[0] = 1'b0; ch_fault[3] = 1'b1;
        reg_rd = 1'b1; reg_addr = 4'd0;
        @(negedge clk); ch_fault[3] = 1'b0; reg_rd = 1'b0;
        peek(4'd0, v);
        chk("R5 event during read survives", v, 32'h0008_0000);
        do_rd(4'd0, v);
        @(negedge clk); xfer_wrdy = 1'b1; reg_rd = 1'b1; reg_addr = 4'd4;
        @(negedge clk); xfer_wrdy = 1'b0; reg_rd = 1'b0;
        peek(4'd4, v);
        chk("R5 wrdy during read survives", v, 32'h0000_0001);
        do_rd(4'd4, v);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        do_wr(4'd1, 32'h5);
        peek(4'd3, v);
        chk("R6 enable sets mask", v, 32'h5);
        do_wr(4'd1, 32'h0);
        peek(4'd3, v);
        chk("R6 enable of zero no effect", v, 32'h5);
        do_wr(4'd2, 32'h4);
        peek(4'd3, v);
        chk("R6 disable clears mask", v, 32'h1);
        do_wr(4'd2, 32'h0);
        peek(4'd3, v);
        chk("R6 disable of zero no effect", v, 32'h1);
        do_wr(4'd5, 32'h1);
        peek(4'd7, v);
        chk("R6 second mask set", v, 32'h1);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        @(negedge clk); ch_eop[1] = 1'b1;
        @(negedge clk); ch_eop[1] = 1'b0;
        #1 chk("R7 unmasked flag no irq", {31'h0, irq}, 32'h0);
        @(negedge clk); ch_eop[0] = 1'b1;
        @(negedge clk); ch_eop[0] = 1'b0;
        #1 chk("R7 masked flag raises irq", {31'h0, irq}, 32'h1);
        do_rd(4'd0, v);
        #1 chk("R7 irq drops after read", {31'h0, irq}, 32'h0);
        @(negedge clk); xfer_wrdy = 1'b1;
        @(negedge clk); xfer_wrdy = 1'b0;
        #1 chk("R7 second register irq", {31'h0, irq}, 32'h1);
        do_rd(4'd4, v);
        #1 chk("R7 irq drops after second read", {31'h0, irq}, 32'h0);
        do_wr(4'd2, 32'hFFFF_FFFF);
        do_wr(4'd6, 32'hFFFF_FFFF);
    endtask

    task automatic t_shadow;
        logic [31:0] v;
        do_wr(4'd8, 32'h30);
        peek(4'd8, v);
        chk("R8 value not active before boundary", v, 32'h0);
        ch0_periods(1);
        peek(4'd8, v);
        chk("R8 value loaded at boundary", v, 32'h30);
        peek(4'd4, v);
        chk("R2 update flag bit16", v, 32'h0001_0000);
        do_rd(4'd4, v);
        ch0_periods(1);
        peek(4'd4, v);
        chk("R10 no update flag without pending", v, 32'h0);
        do_wr(4'd9, 32'h31);
        ch0_periods(1);
        peek(4'd9, v);
        chk("R9 config loaded", v, 32'h31);
        do_rd(4'd4, v);
        do_wr(4'd8, 32'h40);
        ch0_periods(3);
        peek(4'd8, v);
        chk("R10 no load before period of four", v, 32'h30);
        peek(4'd4, v);
        chk("R10 no update flag mid period", v, 32'h0);
        ch0_periods(1);
        peek(4'd8, v);
        chk("R10 load on fourth period", v, 32'h40);
        peek(4'd9, v);
        chk("R9 config kept when not written", v, 32'h31);
        peek(4'd4, v);
        chk("R10 update flag at boundary", v, 32'h0001_0000);
        do_rd(4'd4, v);
        do_rd(4'd0, v);
    endtask

    task automatic t_match;
        logic [31:0] v;
        @(negedge clk); ch0_cnt = 16'h3F;
        #1 chk("R11 no match off value", {30'h0, cmp_match}, 32'h0);
        @(negedge clk); ch0_cnt = 16'h40;
        #1 chk("R11 match pulse on equal", {30'h0, cmp_match}, 32'h1);
        @(negedge clk);
        #1 chk("R11 match only one cycle", {30'h0, cmp_match}, 32'h0);
        peek(4'd4, v);
        chk("R2 match flag bit8", v, 32'h0000_0100);
        @(negedge clk); ch0_cnt = 16'h0;
        #1 chk("R11 disabled comparator silent", {30'h0, cmp_match}, 32'h0);
        do_rd(4'd4, v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sr1();
        t_sr2();
        t_collision();
        t_mask();
        t_irq();
        t_shadow();
        t_match();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule